// File: doc/BRIEF.md
# Indexed PWM Channel Bank

This block holds a bank of independent 8-bit pulse-width generators, sixteen by default. Software programs it through a small byte-wide register window. One register is an index: it names the channel that the clock-source, period and width registers read and write. A fifth register sets a programmable divider ratio that all channels share. Each channel produces one output bit. A single interrupt line is raised in every cycle in which any output bit has changed.

Each channel runs a small phase machine with four states. PH_OFF means the active width is zero. PH_FULL means the active width is nonzero and at least the active period. PH_HIGH means the count is below the width. PH_LOW means the count has reached the width. The transition HIGH to LOW happens when the count reaches the width. The transition LOW to HIGH happens when the count wraps at the period boundary. The transitions into and out of OFF and FULL happen only when new values are loaded at a boundary. The counter advances only on the tick of the channel's chosen time base. On the terminal tick it wraps to zero and loads the pending period and width.

Top module: `pwm_bank`

## Requirements
- R1: Writing offset 0 with a value below N_CH selects that channel. A written value of N_CH or more is ignored. Reading offset 0 returns the current index, and the index is 0 after reset.
- R2: Offsets 1 (source), 2 (period) and 3 (width) read and write the values held for the selected channel. Offset 4 holds the divider ratio. Offsets 5 to 7 read as 0. `rd_data` is updated in the cycle after the cycle in which `rd_en` is sampled, and it holds its value otherwise.
- R3: The source code picks a time base. Code 0 ticks every cycle. Codes 1, 2 and 3 tick once every PRE_A, PRE_B and PRE_C cycles. Code 4 is the programmable divider applied to the system clock. Code 5 is the programmable divider applied to the code-1 ticks. A write of code 6 or 7 is ignored.
- R4: The divider fires once every R input ticks, where R is the ratio at offset 4. A ratio of 0 behaves as 1. All channels share the one ratio.
- R5: On each tick the count advances. After count P-1 it wraps to 0, so one period is P ticks. The output is high while the count is below the width W.
- R6: When the active width is 0, the output is low. When the active width is nonzero and at least the active period, the output is high.
- R7: A new period or width takes effect only at a period boundary. A boundary is the tick on which the count wraps, or any tick while the active period is 0 or 1. The count is 0 whenever the active values change.
- R8: `irq_o` is high in exactly those cycles in which `pwm_o` differs from its value in the previous cycle.
- R9: After reset, all stored values are 0, `pwm_o` is all low and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| pwm_o | output | N_CH | One output per channel |
| irq_o | output | 1 | Output-change indication |

## Verification
The assertions check the following on every cycle, for every channel. An idle width forces the output low, and a saturating width forces it high. The output within a period follows the count. The active period and width change only while the count is zero. The interrupt tracks output edges. Only the bench's scenarios can show the rest: the spacing of the six time bases, the divider's zero-as-one rule, the behaviour of the index register, ignored writes, and the exact cycle in which a value written mid-period takes over. These are shown by comparing against the behavioural model over long runs and by register readback.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int ADDR_W  = 3;
    localparam int NUM_SRC = 6;

    localparam logic [ADDR_W-1:0] OFS_INDEX  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_SOURCE = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_WIDTH  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_RATIO  = 3'd4;

    typedef enum logic [2:0] {
        SRC_EVERY  = 3'd0,
        SRC_PRE_A  = 3'd1,
        SRC_PRE_B  = 3'd2,
        SRC_PRE_C  = 3'd3,
        SRC_DIV_CK = 3'd4,
        SRC_DIV_A  = 3'd5
    } src_e;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_FULL = 2'd3
    } phase_e;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_bank_pkg::*;
#(
    parameter int PRE_A = 16,
    parameter int PRE_B = 256,
    parameter int PRE_C = 750
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          ratio,
    output logic [NUM_SRC-1:0]  tick_o
);

    logic [2:0] pre_tick;

    for (genvar k = 0; k < 3; k++) begin : g_pre
        localparam int LIM = (k == 0) ? PRE_A : ((k == 1) ? PRE_B : PRE_C);
        localparam int CW  = (LIM > 1) ? $clog2(LIM) : 1;
        logic [CW-1:0] c_q;

        assign pre_tick[k] = (c_q == CW'(LIM - 1));

        always_ff @(posedge clk) begin
            if (rst)              c_q <= '0;
            else if (pre_tick[k]) c_q <= '0;
            else                  c_q <= c_q + 1'b1;
        end
    end

    logic [7:0] r_lim;
    logic [7:0] dck_q, da_q;
    logic       dck_hit, da_hit;

    assign r_lim   = (ratio == 8'd0) ? 8'd0 : ratio - 8'd1;
    assign dck_hit = (dck_q >= r_lim);
    assign da_hit  = (da_q >= r_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            dck_q <= '0;
            da_q  <= '0;
        end else begin
            dck_q <= dck_hit ? 8'd0 : dck_q + 8'd1;
            if (pre_tick[0])
                da_q <= da_hit ? 8'd0 : da_q + 8'd1;
        end
    end

    assign tick_o[SRC_EVERY]  = 1'b1;
    assign tick_o[SRC_PRE_A]  = pre_tick[0];
    assign tick_o[SRC_PRE_B]  = pre_tick[1];
    assign tick_o[SRC_PRE_C]  = pre_tick[2];
    assign tick_o[SRC_DIV_CK] = dck_hit;
    assign tick_o[SRC_DIV_A]  = pre_tick[0] & da_hit;

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_bank_pkg::*;
#(
    parameter int N_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    output logic [2:0]        src_q [N_CH],
    output logic [7:0]        per_q [N_CH],
    output logic [7:0]        wid_q [N_CH],
    output logic [7:0]        ratio_q
);

    localparam int SW = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [SW-1:0] sel_q;
    logic [7:0]    rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            ratio_q <= '0;
            for (int i = 0; i < N_CH; i++) begin
                src_q[i] <= '0;
                per_q[i] <= '0;
                wid_q[i] <= '0;
            end
        end else if (wr_en) begin
            unique case (addr)
                OFS_INDEX:  if (32'(wdata) < N_CH)    sel_q        <= wdata[SW-1:0];
                OFS_SOURCE: if (32'(wdata) < NUM_SRC) src_q[sel_q] <= wdata[2:0];
                OFS_PERIOD: per_q[sel_q] <= wdata;
                OFS_WIDTH:  wid_q[sel_q] <= wdata;
                OFS_RATIO:  ratio_q      <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            OFS_INDEX:  rd_mux = 8'(sel_q);
            OFS_SOURCE: rd_mux = 8'(src_q[sel_q]);
            OFS_PERIOD: rd_mux = per_q[sel_q];
            OFS_WIDTH:  rd_mux = wid_q[sel_q];
            OFS_RATIO:  rd_mux = ratio_q;
            default:    rd_mux = 8'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [7:0] per_new,
    input  logic [7:0] wid_new,
    output logic       pwm_o,
    output logic [7:0] cnt_o,
    output logic [7:0] pact_o,
    output logic [7:0] wact_o
);

    logic [7:0] cnt_q, pact_q, wact_q;
    logic       wrap;
    phase_e     phase;

    assign wrap = ({1'b0, cnt_q} + 9'd1) >= {1'b0, pact_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pact_q <= '0;
            wact_q <= '0;
        end else if (tick) begin
            if (wrap) begin
                cnt_q  <= '0;
                pact_q <= per_new;
                wact_q <= wid_new;
            end else begin
                cnt_q  <= cnt_q + 8'd1;
            end
        end
    end

    always_comb begin
        if (wact_q == 8'd0)        phase = PH_OFF;
        else if (wact_q >= pact_q) phase = PH_FULL;
        else if (cnt_q < wact_q)   phase = PH_HIGH;
        else                       phase = PH_LOW;
    end

    always_comb begin
        unique case (phase)
            PH_HIGH, PH_FULL: pwm_o = 1'b1;
            PH_OFF,  PH_LOW:  pwm_o = 1'b0;
            default:          pwm_o = 1'b0;
        endcase
    end

    assign cnt_o  = cnt_q;
    assign pact_o = pact_q;
    assign wact_o = wact_q;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int N_CH  = 16,
    parameter int PRE_A = 16,
    parameter int PRE_B = 256,
    parameter int PRE_C = 750
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    output logic [N_CH-1:0]   pwm_o,
    output logic              irq_o
);

    logic [2:0]         ch_src  [N_CH];
    logic [7:0]         ch_per  [N_CH];
    logic [7:0]         ch_wid  [N_CH];
    logic [7:0]         ch_cnt  [N_CH];
    logic [7:0]         ch_pact [N_CH];
    logic [7:0]         ch_wact [N_CH];
    logic [7:0]         ratio;
    logic [NUM_SRC-1:0] ticks;
    logic [7:0]         ticks_pad;
    logic [N_CH-1:0]    pwm_prev;

    pwm_regfile #(.N_CH(N_CH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .src_q   (ch_src),
        .per_q   (ch_per),
        .wid_q   (ch_wid),
        .ratio_q (ratio)
    );

    pwm_tick_gen #(.PRE_A(PRE_A), .PRE_B(PRE_B), .PRE_C(PRE_C)) u_ticks (
        .clk    (clk),
        .rst    (rst),
        .ratio  (ratio),
        .tick_o (ticks)
    );

    assign ticks_pad = {{(8-NUM_SRC){1'b0}}, ticks};

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        pwm_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (ticks_pad[ch_src[i]]),
            .per_new (ch_per[i]),
            .wid_new (ch_wid[i]),
            .pwm_o   (pwm_o[i]),
            .cnt_o   (ch_cnt[i]),
            .pact_o  (ch_pact[i]),
            .wact_o  (ch_wact[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) pwm_prev <= '0;
        else     pwm_prev <= pwm_o;
    end

    assign irq_o = |(pwm_o ^ pwm_prev);

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int N_CH = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [N_CH-1:0] pwm_o,
    input logic            irq_o,
    input logic [7:0]      ch_cnt  [N_CH],
    input logic [7:0]      ch_pact [N_CH],
    input logic [7:0]      ch_wact [N_CH]
);

    a_r8_irq_tracks_edges: assert property (@(posedge clk) disable iff (rst)
        irq_o == (pwm_o != $past(pwm_o)))
        else $error("R8 interrupt does not match output edges");

    for (genvar i = 0; i < N_CH; i++) begin : g_a
        a_r6_zero_width_low: assert property (@(posedge clk) disable iff (rst)
            (ch_wact[i] == 8'd0) |-> !pwm_o[i])
            else $error("R6 channel %0d high with zero width", i);

        a_r6_full_width_high: assert property (@(posedge clk) disable iff (rst)
            (ch_wact[i] != 8'd0 && ch_wact[i] >= ch_pact[i]) |-> pwm_o[i])
            else $error("R6 channel %0d low with saturating width", i);

        a_r5_follows_count: assert property (@(posedge clk) disable iff (rst)
            (ch_wact[i] != 8'd0 && ch_wact[i] < ch_pact[i]) |->
                (pwm_o[i] == (ch_cnt[i] < ch_wact[i])))
            else $error("R5 channel %0d level disagrees with count", i);

        a_r7_load_at_boundary: assert property (@(posedge clk) disable iff (rst)
            (!$stable(ch_wact[i]) || !$stable(ch_pact[i])) |-> (ch_cnt[i] == 8'd0))
            else $error("R7 channel %0d loaded away from boundary", i);
    end

endmodule

bind pwm_bank pwm_bank_chk #(.N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pwm_o   (pwm_o),
    .irq_o   (irq_o),
    .ch_cnt  (ch_cnt),
    .ch_pact (ch_pact),
    .ch_wact (ch_wact)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;

    localparam int NC = 16;
    localparam int PA = 3;
    localparam int PB = 5;
    localparam int PC = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rd_data;
    logic [NC-1:0] pwm_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pwm_bank #(.N_CH(NC), .PRE_A(PA), .PRE_B(PB), .PRE_C(PC)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .pwm_o(pwm_o), .irq_o(irq_o)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_cnt[NC], m_pa[NC], m_wa[NC], m_ps[NC], m_ws[NC], m_src[NC];
    int m_sel, m_div, m_pra, m_prb, m_prc, m_da, m_db;
    bit [NC-1:0] m_pwm, m_old;
    bit m_irq;
    bit tk[6];
    int r;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NC; i++) begin
                m_cnt[i] = 0; m_pa[i] = 0; m_wa[i] = 0;
                m_ps[i] = 0; m_ws[i] = 0; m_src[i] = 0;
            end
            m_sel = 0; m_div = 0; m_pra = 0; m_prb = 0; m_prc = 0;
            m_da = 0; m_db = 0; m_pwm = '0; m_irq = 0;
        end else begin
            r = (m_div == 0) ? 1 : m_div;
            tk[0] = 1;
            tk[1] = (m_pra == PA - 1);
            tk[2] = (m_prb == PB - 1);
            tk[3] = (m_prc == PC - 1);
            tk[4] = (m_da >= r - 1);
            tk[5] = tk[1] && (m_db >= r - 1);
            for (int i = 0; i < NC; i++) begin
                if (tk[m_src[i]]) begin
                    if (m_cnt[i] + 1 >= m_pa[i]) begin
                        m_cnt[i] = 0; m_pa[i] = m_ps[i]; m_wa[i] = m_ws[i];
                    end else m_cnt[i]++;
                end
            end
            m_old = m_pwm;
            for (int i = 0; i < NC; i++)
                m_pwm[i] = (m_wa[i] == 0) ? 1'b0 :
                           (m_wa[i] >= m_pa[i]) ? 1'b1 : (m_cnt[i] < m_wa[i]);
            m_irq = (m_pwm != m_old);
            if (wr_en) begin
                case (addr)
                    3'd0: if (wdata < NC) m_sel = wdata;
                    3'd1: if (wdata < 6)  m_src[m_sel] = wdata;
                    3'd2: m_ps[m_sel] = wdata;
                    3'd3: m_ws[m_sel] = wdata;
                    3'd4: m_div = wdata;
                    default: ;
                endcase
            end
            m_pra = tk[1] ? 0 : m_pra + 1;
            m_prb = tk[2] ? 0 : m_prb + 1;
            m_prc = tk[3] ? 0 : m_prc + 1;
            m_da  = tk[4] ? 0 : m_da + 1;
            if (tk[1]) m_db = (m_db >= r - 1) ? 0 : m_db + 1;
        end
    end

    // per-cycle comparison: R3 R4 R5 R6 R7 on the outputs, R8 on the interrupt
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(pwm_o == m_pwm, "R3 R4 R5 R6 R7", "pwm_o", int'(pwm_o), int'(m_pwm));
            chk(irq_o == m_irq, "R8", "irq_o", int'(irq_o), int'(m_irq));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == exp[7:0], req, "rd_data", int'(rd_data), exp);
    endtask

    task automatic setup_ch(input int ch, input int src, input int per, input int wid);
        wr(3'd0, 8'(ch));
        wr(3'd1, 8'(src));
        wr(3'd2, 8'(per));
        wr(3'd3, 8'(wid));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk(pwm_o == '0, "R9", "pwm_o after reset", int'(pwm_o), 0);
        chk(irq_o == 1'b0, "R9", "irq_o after reset", int'(irq_o), 0);
        rd_chk(3'd0, 0, "R9 index");
        rd_chk(3'd2, 0, "R9 period");
        rd_chk(3'd3, 0, "R9 width");
        rd_chk(3'd4, 0, "R9 ratio");

        wr(3'd4, 8'd3);
        setup_ch(0, 0, 4, 1);
        setup_ch(1, 1, 5, 2);
        setup_ch(2, 2, 3, 3);
        setup_ch(3, 3, 6, 0);
        setup_ch(4, 4, 4, 2);
        setup_ch(5, 5, 2, 1);
        setup_ch(6, 0, 0, 5);
        setup_ch(7, 3, 10, 12);
        setup_ch(8, 1, 7, 3);

        // R2 readback of the selected channel
        wr(3'd0, 8'd1);
        rd_chk(3'd1, 1, "R2 source");
        rd_chk(3'd2, 5, "R2 period");
        rd_chk(3'd3, 2, "R2 width");
        rd_chk(3'd4, 3, "R4 ratio");
        rd_chk(3'd6, 0, "R2 unmapped");
        // R1 out-of-range index is ignored
        wr(3'd0, 8'h10);
        rd_chk(3'd0, 1, "R1 index kept");
        rd_chk(3'd2, 5, "R1 still channel 1");
        // R3 invalid source code is ignored
        wr(3'd1, 8'd6);
        rd_chk(3'd1, 1, "R3 source kept");
        wr(3'd0, 8'd15);
        rd_chk(3'd0, 15, "R1 top index");

        idle(300);
        // R7 mid-period updates
        wr(3'd0, 8'd0);
        wr(3'd3, 8'd3);
        wr(3'd0, 8'd8);
        wr(3'd2, 8'd4);
        idle(300);
        // R4 ratio zero acts as one
        wr(3'd4, 8'd0);
        idle(200);
        wr(3'd4, 8'd7);
        wr(3'd0, 8'd4);
        wr(3'd2, 8'd1);
        idle(400);
        wr(3'd3, 8'd0);
        idle(100);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule